// File: doc/BRIEF.md
# Interrupt Status and Clear-on-Read Unit

This block gathers twelve event sources of a two-wire serial bus controller into one raw status vector. Ten of the sources are sticky: a single-cycle pulse sets the bit, and the bit stays set until software reads a clear register. The receive-full and transmit-empty sources are level sources. Their bits follow the input and no read clears them. A software mask selects which raw bits reach the masked status and the single interrupt line. The interrupt line is held low while the controller is disabled.

Every source has its own clear register. A read of that register returns the bit as it was before the read and clears only that bit. A separate combined-clear register clears all sticky bits at once. Each transmit-abort event also ORs a reason vector into an abort-reason register. That register is emptied when the abort clear register or the combined-clear register is read. A service-pending output tells the controller that something needs attention. A raw status with only the activity bit set does not count as pending.

Register access uses a plain strobe bus. A read strobe and a write strobe are each one cycle long, and read data is registered. The event generators are outside this block. They appear here only as input pulses and input levels.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset, the raw status, the mask, the abort reason, the read data, the interrupt output and the service-pending output are all 0.
- R2: The source bit positions are: 0 receive underflow, 1 receive overflow, 2 receive full, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop detected, 10 start detected, 11 general call. A pulse on a sticky source (every bit except 2 and 4) sets its raw bit at the next clock edge. The raw status is read at address 0x00.
- R3: Level bits 2 and 4 take the value their input had at the previous clock edge. A clear read leaves them unchanged.
- R4: The mask is read and written at address 0x01, using bits 11:0. The masked status is read at address 0x02 and equals raw AND mask.
- R5: A read of address 0x05+i (i = 0..11) returns the previous raw bit i in data bit 0. It clears sticky bit i and leaves every other bit unchanged.
- R6: A read of address 0x03 returns the previous raw status and clears every sticky bit.
- R7: When a transmit-abort pulse (bit 6) arrives, the abort-reason input is ORed into the abort-reason register. The register is read at address 0x04. Reads of 0x0B and 0x03 clear it. The reason input has no effect without an abort pulse.
- R8: An event that arrives in the same cycle as a read that clears its bit wins. The bit stays set, and the abort reason becomes the incoming reason vector.
- R9: The interrupt output is the OR of the masked status bits. It is 0 whenever the controller enable is 0.
- R10: The service-pending output is 1 exactly when the controller enable is 1 and some raw bit other than bit 8 (activity) is set.
- R11: Reads of addresses 0x11 to 0x1F return 0. Writes to any address other than 0x01 change no state.
- R12: Read data appears in the cycle after the read strobe. Read data is 0 in any cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; gates the interrupt and service outputs |
| evt_in | input | 12 | Event pulses (sticky bits) and levels (bits 2 and 4) |
| abort_reason_in | input | 12 | Abort cause vector, sampled with the transmit-abort pulse |
| bus_addr | input | 5 | Register word address |
| bus_rd | input | 1 | Read strobe; reading clear registers has side effects |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| svc_pending_o | output | 1 | Controller has a non-activity event to service |

## Verification
A pulse or level driven before clock edge N shows up in the raw status after edge N. A read strobed before edge N returns its data after edge N and clears its bits at that same edge. The interrupt and service outputs are combinational from registered state, so they change right after the edge that updates the raw status or the mask, and at once when the enable changes. The bench drives every input on the falling edge and samples one falling edge after the strobe. It checks the enable gating a moment after the enable changes. It sweeps every source through set, own-clear and combined-clear, and checks that the other bits are left alone each time.

// File: rtl/irq_stat_pkg.sv
// Shared constants for the interrupt status unit.
// Assumes a fixed set of twelve sources whose bit positions software decodes.
package irq_stat_pkg;
    localparam int NSRC       = 12;
    localparam int A_RAW      = 0;
    localparam int A_MASK     = 1;
    localparam int A_MSTAT    = 2;
    localparam int A_CLRALL   = 3;
    localparam int A_REASON   = 4;
    localparam int A_CLR_BASE = 5;
    localparam int BIT_ABRT   = 6;
    localparam int BIT_ACT    = 8;
    localparam logic [NSRC-1:0] LEVEL_SRC  = 12'h014;
    localparam logic [NSRC-1:0] STICKY_SRC = ~LEVEL_SRC;
endpackage

// File: rtl/irq_src_cell.sv
// One raw status bit. IS_LEVEL picks the variant:
// a level bit registers its input, and a sticky bit is set by a pulse and cleared by clr.
// Assumes clr is already qualified by the read strobe. The event wins over clr.
module irq_src_cell #(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic q
);
    generate
        if (IS_LEVEL) begin : g_level
            // Purpose: follow the level input one cycle late.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= evt;
            end
        end else begin : g_sticky
            // Purpose: set on a pulse, clear on a read, with the pulse taking priority.
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= 1'b0;
                else if (evt) q <= 1'b1;
                else if (clr) q <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_abort_latch.sv
// Accumulates abort cause bits while an abort is pending.
// Assumes capture is the transmit-abort pulse. A capture in the same cycle as a clear
// loads the incoming vector only.
module irq_abort_latch #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] reason_in,
    input  logic         clr,
    output logic [W-1:0] reason_q
);
    // Purpose: hold the OR of the causes seen since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reason_q <= '0;
        else if (clr)
            reason_q <= capture ? reason_in : '0;
        else if (capture)
            reason_q <= reason_q | reason_in;
    end
endmodule

// File: rtl/irq_bus_port.sv
// Register decode for the status unit: holds the mask, makes the per-bit clear
// strobes, and registers the read data. Assumes strobes last one cycle.
module irq_bus_port
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   raw,
    input  logic [NSRC-1:0]   reason,
    output logic [NSRC-1:0]   mask_q,
    output logic [NSRC-1:0]   clr_vec,
    output logic              reason_clr,
    output logic [DATA_W-1:0] rdata
);
    logic              hit_all;
    logic [DATA_W-1:0] rd_val;

    assign hit_all = (addr == ADDR_W'(A_CLRALL));

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_clr
            assign clr_vec[gi] = rd && (hit_all || addr == ADDR_W'(A_CLR_BASE + gi));
        end
    endgenerate

    assign reason_clr = rd && (hit_all || addr == ADDR_W'(A_CLR_BASE + BIT_ABRT));

    // Purpose: mask register, written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr && addr == ADDR_W'(A_MASK))
            mask_q <= wdata[NSRC-1:0];
    end

    // Purpose: select the value returned for the addressed register.
    always_comb begin
        rd_val = '0;
        if (addr == ADDR_W'(A_RAW) || hit_all) rd_val = DATA_W'(raw);
        if (addr == ADDR_W'(A_MASK))           rd_val = DATA_W'(mask_q);
        if (addr == ADDR_W'(A_MSTAT))          rd_val = DATA_W'(raw & mask_q);
        if (addr == ADDR_W'(A_REASON))         rd_val = DATA_W'(reason);
        for (int i = 0; i < NSRC; i++) begin
            if (addr == ADDR_W'(A_CLR_BASE + i)) rd_val = DATA_W'(raw[i]);
        end
    end

    // Purpose: register read data for one cycle per strobe, and return 0 otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd ? rd_val : '0;
    end
endmodule

// File: rtl/irq_status_unit.sv
// Top of the interrupt status unit. It collects twelve sources into a raw vector,
// masks them into one interrupt, and clears them on reads.
// Assumes the event pulses are synchronous to clk.
module irq_status_unit
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic [NSRC-1:0]   evt_in,
    input  logic [NSRC-1:0]   abort_reason_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              svc_pending_o
);
    logic [NSRC-1:0] raw_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] reason_q;
    logic [NSRC-1:0] clr_vec;
    logic            reason_clr;
    logic [NSRC-1:0] act_mask;

    assign act_mask = NSRC'(1) << BIT_ACT;

    genvar gs;
    generate
        for (gs = 0; gs < NSRC; gs++) begin : g_src
            irq_src_cell #(.IS_LEVEL(LEVEL_SRC[gs])) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (evt_in[gs]),
                .clr   (clr_vec[gs]),
                .q     (raw_q[gs])
            );
        end
    endgenerate

    irq_abort_latch #(.W(NSRC)) u_abort (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (evt_in[BIT_ABRT]),
        .reason_in (abort_reason_in),
        .clr       (reason_clr),
        .reason_q  (reason_q)
    );

    irq_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .wdata      (bus_wdata),
        .raw        (raw_q),
        .reason     (reason_q),
        .mask_q     (mask_q),
        .clr_vec    (clr_vec),
        .reason_clr (reason_clr),
        .rdata      (bus_rdata)
    );

    // Purpose: a single interrupt from the masked status, gated by the enable.
    assign irq_o         = ctrl_en && |(raw_q & mask_q);
    // Purpose: service request that ignores a lone activity bit.
    assign svc_pending_o = ctrl_en && |(raw_q & ~act_mask);
endmodule

// File: rtl/irq_status_chk.sv
// Checker for irq_status_unit. It watches ports and the raw, mask and reason state.
module irq_status_chk
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_en,
    input logic [NSRC-1:0]   evt,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic [NSRC-1:0]   raw,
    input logic [NSRC-1:0]   mask,
    input logic [NSRC-1:0]   reason,
    input logic              irq,
    input logic              svc
);
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & STICKY_SRC) != '0 |=> (raw & $past(evt & STICKY_SRC)) == $past(evt & STICKY_SRC)); // R2
    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rd && evt[0] |=> raw[0]); // R8
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (raw & LEVEL_SRC) == ($past(evt) & LEVEL_SRC)); // R3
    AST_NO_SPONT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (raw & $past(raw) & STICKY_SRC) == ($past(raw) & STICKY_SRC)); // R5
    AST_REASON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rd && (addr == ADDR_W'(A_CLRALL) || addr == ADDR_W'(A_CLR_BASE + BIT_ABRT)) && !evt[BIT_ABRT]
        |=> reason == '0); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !irq); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & mask) == '0 |-> !irq); // R4
    AST_SVC_ACT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~(NSRC'(1) << BIT_ACT)) == '0 |-> !svc); // R10
endmodule

bind irq_status_unit irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_en (ctrl_en),
    .evt     (evt_in),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .raw     (raw_q),
    .mask    (mask_q),
    .reason  (reason_q),
    .irq     (irq_o),
    .svc     (svc_pending_o)
);

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
    localparam logic [11:0] LVL = 12'h014;
    localparam logic [11:0] STK = ~LVL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b1;
    logic [11:0] pulse = '0;
    logic [11:0] lvl = '0;
    logic [11:0] rsn = '0;
    logic [4:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, svc;
    logic [11:0] evt;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    assign evt = pulse | (lvl & LVL);
    always #10 clk = ~clk;

    irq_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .evt_in(evt),
        .abort_reason_in(rsn), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .svc_pending_o(svc)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd_pulse(input logic [4:0] a, input logic [11:0] p, input logic [11:0] r,
                            output logic [15:0] v);
        @(negedge clk); rd = 1'b1; addr = a; pulse = p; rsn = r;
        @(negedge clk); v = rdata; rd = 1'b0; pulse = '0; rsn = '0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [15:0] v);
        rd_pulse(a, '0, '0, v);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic fire(input logic [11:0] p, input logic [11:0] r);
        @(negedge clk); pulse = p; rsn = r;
        @(negedge clk); pulse = '0; rsn = '0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        logic [15:0] v;
        logic [11:0] m;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", {15'b0, irq}, 16'h0);
        check("R1 svc", {15'b0, svc}, 16'h0);
        check("R1 rdata", rdata, 16'h0);
        rst_n = 1'b1;
        rd_reg(5'h00, v); check("R1 raw", v, 16'h0);
        rd_reg(5'h01, v); check("R1 mask", v, 16'h0);
        rd_reg(5'h04, v); check("R1 reason", v, 16'h0);
        // R12 read data returns to 0 after a cycle without a strobe
        @(negedge clk); check("R12 idle rdata", rdata, 16'h0);

        // R2 and R5: each sticky bit alone
        for (int i = 0; i < 12; i++) begin
            if (!STK[i]) continue;
            fire(12'(1 << i), '0);
            rd_reg(5'h00, v); check("R2 set", v, 16'(1 << i));
            rd_reg(5'(5 + i), v); check("R5 prior bit", v, 16'h1);
            rd_reg(5'h00, v); check("R5 cleared", v, 16'h0);
        end
        // R5 and R6: own clear leaves the others set, and the combined clear empties all
        for (int i = 0; i < 12; i++) begin
            if (!STK[i]) continue;
            fire(STK, '0);
            rd_reg(5'(5 + i), v);
            rd_reg(5'h00, v); check("R5 only own", v, 16'(STK & ~12'(1 << i)));
            rd_reg(5'h03, v); check("R6 clrall returns", v, 16'(STK & ~12'(1 << i)));
            rd_reg(5'h00, v); check("R6 all cleared", v, 16'h0);
        end
        rd_reg(5'h04, v); check("R7 reason clrall", v, 16'h0);

        // R3 level sources
        @(negedge clk); lvl = LVL;
        @(negedge clk);
        rd_reg(5'h00, v); check("R3 level follow", v, 16'h014);
        rd_reg(5'h07, v); check("R3 clear read prior", v, 16'h1);
        rd_reg(5'h03, v); check("R3 clrall prior", v, 16'h014);
        rd_reg(5'h00, v); check("R3 survives clear", v, 16'h014);
        @(negedge clk); lvl = '0;
        @(negedge clk);
        rd_reg(5'h00, v); check("R3 level drop", v, 16'h0);

        // R4 and R9 mask sweep
        for (int k = 0; k < 6; k++) begin
            m = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : (k == 2) ? 12'h200 :
                (k == 3) ? 12'h1FF : (k == 4) ? 12'hA55 : 12'h5AA;
            wr_reg(5'h01, {4'h0, m});
            fire(12'h201, '0);
            rd_reg(5'h01, v); check("R4 mask rw", v, {4'h0, m});
            rd_reg(5'h02, v); check("R4 masked", v, {4'h0, m & 12'h201});
            check("R9 irq or", {15'b0, irq}, {15'b0, (m & 12'h201) != 0});
            check("R10 svc", {15'b0, svc}, 16'h1);
            @(negedge clk); ctrl_en = 1'b0; #1;
            check("R9 irq gated", {15'b0, irq}, 16'h0);
            check("R10 svc gated", {15'b0, svc}, 16'h0);
            ctrl_en = 1'b1;
            rd_reg(5'h03, v);
        end

        // R10 the activity bit alone
        wr_reg(5'h01, 16'h0100);
        fire(12'h100, '0);
        check("R10 act only svc", {15'b0, svc}, 16'h0);
        check("R9 act irq", {15'b0, irq}, 16'h1);
        fire(12'h001, '0);
        check("R10 other svc", {15'b0, svc}, 16'h1);
        rd_reg(5'h03, v);

        // R7 abort reason
        fire(12'h040, 12'h008);
        fire(12'h040, 12'h001);
        fire(12'h001, 12'h004);
        rd_reg(5'h04, v); check("R7 reason or", v, 16'h009);
        rd_reg(5'h0B, v); check("R7 abort clr prior", v, 16'h1);
        rd_reg(5'h04, v); check("R7 reason cleared", v, 16'h0);
        rd_reg(5'h00, v); check("R7 bit0 kept", v, 16'h001);
        fire(12'h040, 12'h800);
        rd_reg(5'h03, v);
        rd_reg(5'h04, v); check("R7 reason clrall", v, 16'h0);

        // R8 same-cycle event wins
        fire(12'h001, '0);
        rd_pulse(5'h05, 12'h001, '0, v); check("R8 prior", v, 16'h1);
        rd_reg(5'h00, v); check("R8 bit kept", v, 16'h001);
        fire(12'h040, 12'h008);
        rd_pulse(5'h0B, 12'h040, 12'h002, v);
        rd_reg(5'h04, v); check("R8 reason new", v, 16'h002);
        rd_pulse(5'h03, 12'h200, '0, v); check("R8 clrall prior", v, 16'h041);
        rd_reg(5'h00, v); check("R8 clrall kept", v, 16'h200);
        rd_reg(5'h03, v);

        // R11 unmapped reads and ignored writes
        for (int a = 17; a < 32; a++) begin
            rd_reg(5'(a), v); check("R11 unmapped", v, 16'h0);
        end
        wr_reg(5'h00, 16'hFFFF);
        wr_reg(5'h02, 16'hFFFF);
        wr_reg(5'h04, 16'hFFFF);
        rd_reg(5'h00, v); check("R11 raw untouched", v, 16'h0);
        rd_reg(5'h04, v); check("R11 reason untouched", v, 16'h0);
        rd_reg(5'h01, v); check("R11 mask untouched", v, 16'h0100);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end
endmodule